// File: doc/BRIEF.md
# Pulse-Width Continuous Logic Cell

This cell computes continuous-logic functions of two unsigned operands without any arithmetic datapath. Each operand is turned into a pulse whose high time, counted in clock cycles from a shared frame start, equals the operand value. A programmable two-input Boolean gate combines the two pulse trains cycle by cycle. A counter then measures how long the gate output stayed high during the frame, and that count is the result.

A 4-bit tuning word selects which of the four input minterms drive the gate high, so all sixteen two-input functions are reachable. AND yields the minimum of the operands, OR the maximum, XOR the absolute difference and XNOR its complement against the frame length. Operands and the tuning word are captured once per frame, so the function can change on every frame. Complemented pulse copies are also brought out, so a consumer never has to encode an inverted operand separately.

Top module: `tpcl_cell`

## Requirements
- R1: The frame is FRAME_LEN cycles long. In every frame, `pulse_a` is high for exactly the first A cycles and low for the rest, where A is the captured and clamped value of `opnd_a`. `pulse_b` behaves the same way for `opnd_b`. `pulse_a_n` and `pulse_b_n` are always the inverses of the two pulses.
- R2: Tuning bit i enables the minterm with index i = 2*b + a, where a and b are the current pulse levels. The gate output is high in a cycle exactly when the enabled bit for that cycle's pulse pair is 1.
- R3: Tuning word 4'b1000 (only index 3) produces a result equal to min(A,B). Tuning word 4'b1110 (OR) produces max(A,B).
- R4: Tuning word 4'b0110 (XOR) produces |A-B|. Tuning word 4'b1001 (XNOR) produces FRAME_LEN-|A-B|.
- R5: Tuning word 4'b0111 (NAND) produces FRAME_LEN-min(A,B). Tuning word 4'b0101 produces FRAME_LEN-A. Tuning word 4'b0010 produces max(A-B,0).
- R6: An operand larger than FRAME_LEN is treated as FRAME_LEN.
- R7: Operands and the tuning word are captured only at the clock edge that ends a cycle in which `capture_now` is high. A change at any other time has no effect on the frame in progress.
- R8: Once per frame, `width_out` is loaded with the number of cycles of the frame just ended in which the gate output was high. In the cycle after that load, `width_vld` is high for exactly one cycle. Between loads, `width_out` holds its value.
- R9: A new tuning word can be supplied at every capture, so sixteen consecutive frames can step through all sixteen functions. Each frame's result follows only its own captured word.
- R10: After reset, `width_vld` and `width_out` are 0 and the pulses are low. `capture_now` is high in the first cycle, so the first edge after reset captures the inputs, and no result is reported for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | OPW | Operand a, coded as a pulse width |
| opnd_b | input | OPW | Operand b, coded as a pulse width |
| tune | input | 4 | Tuning word; bit i enables minterm 2*b+a |
| capture_now | output | 1 | High in the last cycle of a frame; inputs are captured at its ending edge |
| pulse_a | output | 1 | Pulse for operand a |
| pulse_a_n | output | 1 | Complement of pulse_a |
| pulse_b | output | 1 | Pulse for operand b |
| pulse_b_n | output | 1 | Complement of pulse_b |
| gate_out | output | 1 | Output of the programmed Boolean gate |
| width_out | output | CW | Measured high time of gate_out in the last frame |
| width_vld | output | 1 | One-cycle strobe that follows each update of width_out |

## Verification
The assertions assume a frame of at least two cycles and inputs that settle away from the capture edge. Under those assumptions, a captured operand or tuning word can only move at a capture, each pulse forms a single run at the head of the frame, and the result strobe never lasts two cycles. The stimulus changes inputs only on falling edges: new values are driven in the capture cycle, and in some frames deliberately wrong values follow one cycle later. Operands above the frame length are also driven on purpose, so the clamp is exercised instead of assumed.

// File: rtl/tpcl_pkg.sv
package tpcl_pkg;

  localparam int unsigned TUNE_W = 4;

  typedef logic [TUNE_W-1:0] tune_t;

  // saturate an operand to the frame length
  function automatic int unsigned clamp_operand(int unsigned value, int unsigned limit);
    return (value > limit) ? limit : value;
  endfunction

  // pulse is high while the phase is below the coded width
  function automatic logic pulse_active(int unsigned phase, int unsigned width);
    return (phase < width);
  endfunction

  // minterm number for a pulse pair: b is the high bit
  function automatic logic [1:0] minterm_index(logic a, logic b);
    return {b, a};
  endfunction

endpackage

// File: rtl/tpcl_frame_timer.sv
module tpcl_frame_timer #(
  parameter int unsigned FRAME_LEN = 255,
  parameter int unsigned CW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] phase,
  output logic          last_cycle,
  output logic          armed
);
  localparam logic [CW-1:0] LAST_PH = CW'(FRAME_LEN - 1);

  logic [CW-1:0] phase_q;
  logic          armed_q;

  // reset parks the phase on the last slot so the first edge captures
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= LAST_PH;
      armed_q <= 1'b0;
    end else if (phase_q == LAST_PH) begin
      phase_q <= '0;
      armed_q <= 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase      = phase_q;
  assign last_cycle = (phase_q == LAST_PH);
  assign armed      = armed_q;
endmodule

// File: rtl/tpcl_pwm_channel.sv
module tpcl_pwm_channel
  import tpcl_pkg::*;
#(
  parameter int unsigned OPW       = 8,
  parameter int unsigned FRAME_LEN = 255,
  parameter int unsigned CW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [OPW-1:0] opnd,
  input  logic [CW-1:0]  phase,
  output logic [CW-1:0]  held,
  output logic           pulse,
  output logic           pulse_n
);
  logic [CW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= CW'(clamp_operand(32'(opnd), FRAME_LEN));
    end
  end

  assign held    = held_q;
  assign pulse   = pulse_active(32'(phase), 32'(held_q));
  assign pulse_n = ~pulse;
endmodule

// File: rtl/tpcl_minterm_gate.sv
module tpcl_minterm_gate
  import tpcl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  tune_t tune_in,
  input  logic  a,
  input  logic  b,
  output tune_t tune_held,
  output logic  gate
);
  tune_t tune_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tune_q <= '0;
    end else if (load) begin
      tune_q <= tune_in;
    end
  end

  assign tune_held = tune_q;
  assign gate      = tune_q[minterm_index(a, b)];
endmodule

// File: rtl/tpcl_width_meter.sv
module tpcl_width_meter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_in,
  input  logic          frame_end,
  input  logic          armed,
  output logic [CW-1:0] width_out,
  output logic          width_vld
);
  logic [CW-1:0] acc_q;
  logic [CW-1:0] width_q;
  logic          vld_q;
  logic [CW-1:0] inc;

  assign inc = {{(CW-1){1'b0}}, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      width_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (frame_end) begin
        acc_q <= '0;
        if (armed) begin
          width_q <= acc_q + inc;
          vld_q   <= 1'b1;
        end
      end else begin
        acc_q <= acc_q + inc;
      end
    end
  end

  assign width_out = width_q;
  assign width_vld = vld_q;
endmodule

// File: rtl/tpcl_cell.sv
module tpcl_cell
  import tpcl_pkg::*;
#(
  parameter int unsigned OPW       = 8,
  parameter int unsigned FRAME_LEN = (1 << OPW) - 1,
  parameter int unsigned CW        = $clog2(FRAME_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opnd_a,
  input  logic [OPW-1:0] opnd_b,
  input  logic [3:0]     tune,
  output logic           capture_now,
  output logic           pulse_a,
  output logic           pulse_a_n,
  output logic           pulse_b,
  output logic           pulse_b_n,
  output logic           gate_out,
  output logic [CW-1:0]  width_out,
  output logic           width_vld
);
  localparam int unsigned NCH = 2;

  // named internal events for the checker
  logic [CW-1:0] phase_w;
  logic          frame_last_w;
  logic          armed_w;
  logic [CW-1:0] held_a;
  logic [CW-1:0] held_b;
  tune_t         tune_held_w;

  logic [OPW-1:0] opnd_arr  [NCH];
  logic [CW-1:0]  held_arr  [NCH];
  logic           pulse_arr [NCH];
  logic           pulsen_arr[NCH];

  assign opnd_arr[0] = opnd_a;
  assign opnd_arr[1] = opnd_b;

  tpcl_frame_timer #(.FRAME_LEN(FRAME_LEN), .CW(CW)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase_w),
    .last_cycle (frame_last_w),
    .armed      (armed_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    tpcl_pwm_channel #(.OPW(OPW), .FRAME_LEN(FRAME_LEN), .CW(CW)) pwm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (frame_last_w),
      .opnd    (opnd_arr[ch]),
      .phase   (phase_w),
      .held    (held_arr[ch]),
      .pulse   (pulse_arr[ch]),
      .pulse_n (pulsen_arr[ch])
    );
  end

  assign held_a = held_arr[0];
  assign held_b = held_arr[1];

  tpcl_minterm_gate gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_last_w),
    .tune_in   (tune),
    .a         (pulse_arr[0]),
    .b         (pulse_arr[1]),
    .tune_held (tune_held_w),
    .gate      (gate_out)
  );

  tpcl_width_meter #(.CW(CW)) meter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (gate_out),
    .frame_end (frame_last_w),
    .armed     (armed_w),
    .width_out (width_out),
    .width_vld (width_vld)
  );

  assign capture_now = frame_last_w;
  assign pulse_a     = pulse_arr[0];
  assign pulse_a_n   = pulsen_arr[0];
  assign pulse_b     = pulse_arr[1];
  assign pulse_b_n   = pulsen_arr[1];
endmodule

// File: rtl/tpcl_cell_chk.sv
module tpcl_cell_chk #(
  parameter int unsigned FRAME_LEN = 255,
  parameter int unsigned CW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          capture_now,
  input logic          pulse_a,
  input logic          pulse_b,
  input logic [CW-1:0] width_out,
  input logic          width_vld,
  input logic [CW-1:0] op_a_held,
  input logic [CW-1:0] op_b_held,
  input logic [3:0]    tune_held
);
  localparam logic [CW-1:0] LIM = CW'(FRAME_LEN);

  assert_vld_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    width_vld |=> !width_vld);

  assert_width_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    width_vld |-> (width_out <= LIM));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(width_out) |-> width_vld);

  assert_pulse_a_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_now && !pulse_a) |=> !pulse_a);

  assert_pulse_b_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture_now && !pulse_b) |=> !pulse_b);

  assert_hold_inputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_now |=> ($stable(op_a_held) && $stable(op_b_held) && $stable(tune_held)));

  assert_capture_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capture_now |=> !capture_now);

  assert_held_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a_held <= LIM) && (op_b_held <= LIM));
endmodule

bind tpcl_cell tpcl_cell_chk #(.FRAME_LEN(FRAME_LEN), .CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .capture_now (capture_now),
  .pulse_a     (pulse_a),
  .pulse_b     (pulse_b),
  .width_out   (width_out),
  .width_vld   (width_vld),
  .op_a_held   (held_a),
  .op_b_held   (held_b),
  .tune_held   (tune_held_w)
);

// File: tb/tpcl_cell_tb_top.sv
module tpcl_cell_tb_top;
  localparam int unsigned OPW = 5;
  localparam int unsigned T   = 20;
  localparam int unsigned CW  = $clog2(T + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [OPW-1:0] opnd_a = '0;
  logic [OPW-1:0] opnd_b = '0;
  logic [3:0]     tune = '0;
  logic           capture_now, pulse_a, pulse_a_n, pulse_b, pulse_b_n, gate_out;
  logic [CW-1:0]  width_out;
  logic           width_vld;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    int    a;
    int    b;
    int    tn;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  tpcl_cell #(.OPW(OPW), .FRAME_LEN(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .tune(tune),
    .capture_now(capture_now), .pulse_a(pulse_a), .pulse_a_n(pulse_a_n),
    .pulse_b(pulse_b), .pulse_b_n(pulse_b_n), .gate_out(gate_out),
    .width_out(width_out), .width_vld(width_vld)
  );

  function automatic int clampv(int v);
    return (v > int'(T)) ? int'(T) : v;
  endfunction

  // region model: both high, one high, both low
  function automatic int model_width(int a, int b, int tn);
    int ac = clampv(a);
    int bc = clampv(b);
    int lo = (ac < bc) ? ac : bc;
    int hi = (ac < bc) ? bc : ac;
    int mid_bit = (ac > bc) ? tn[1] : tn[2];
    return tn[3] * lo + mid_bit * (hi - lo) + tn[0] * (int'(T) - hi);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(int a, int b, int tn, string tag, bit scramble);
    item_t it;
    while (!capture_now) @(negedge clk);
    opnd_a = OPW'(a);
    opnd_b = OPW'(b);
    tune   = 4'(tn);
    it.a = a; it.b = b; it.tn = tn; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    if (scramble) begin
      opnd_a = ~OPW'(a);
      opnd_b = ~OPW'(b);
      tune   = ~4'(tn);
    end
  endtask

  // monitor: counts pulse levels per frame and checks each result
  int cnt_a = 0;
  int cnt_b = 0;
  int cnt_inv = 0;
  bit prev_cap = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_cap && !capture_now) begin
      if (width_vld && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(int'(width_out) == model_width(it.a, it.b, it.tn),
              $sformatf("%s width tune=%b", it.tag, 4'(it.tn)),
              int'(width_out), model_width(it.a, it.b, it.tn));
        check(cnt_a == clampv(it.a), "R1 pulse_a high time", cnt_a, clampv(it.a));
        check(cnt_b == clampv(it.b), "R1 pulse_b high time", cnt_b, clampv(it.b));
        check(cnt_inv == 0, "R1 complement outputs", cnt_inv, 0);
      end
      cnt_a = 0; cnt_b = 0; cnt_inv = 0;
    end
    if (pulse_a) cnt_a++;
    if (pulse_b) cnt_b++;
    if ((pulse_a_n == pulse_a) || (pulse_b_n == pulse_b)) cnt_inv++;
    prev_cap = capture_now;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(width_vld == 1'b0, "R10 width_vld at reset", int'(width_vld), 0);
    check(width_out == '0, "R10 width_out at reset", int'(width_out), 0);
    check(pulse_a == 1'b0 && pulse_a_n == 1'b1, "R10 pulse_a at reset", int'(pulse_a), 0);
    check(capture_now == 1'b1, "R10 capture_now at reset", int'(capture_now), 1);
    rst_n = 1'b1;
    run_frame(6, 13, 4'b1000, "R3 AND=min", 1'b0);
    run_frame(6, 13, 4'b1110, "R3 OR=max", 1'b0);
    run_frame(5, 8, 4'b0110, "R4 XOR=absdiff", 1'b0);
    run_frame(8, 5, 4'b0110, "R4 XOR swapped", 1'b0);
    run_frame(2, 7, 4'b1001, "R4 XNOR", 1'b0);
    run_frame(2, 7, 4'b0111, "R5 NAND", 1'b0);
    run_frame(7, 3, 4'b0101, "R5 NOT a", 1'b0);
    run_frame(12, 4, 4'b0010, "R5 a and not b", 1'b0);
    run_frame(4, 12, 4'b0010, "R5 a and not b zero", 1'b0);
    for (int i = 0; i < 4; i++) run_frame(9, 3, 1 << i, "R2 single minterm", 1'b0);
    run_frame(9, 9, 4'b0110, "R2 equal operands", 1'b0);
    run_frame(31, 25, 4'b1000, "R6 clamp AND", 1'b0);
    run_frame(31, 3, 4'b0101, "R6 clamp NOT a", 1'b0);
    run_frame(0, 20, 4'b1110, "R6 zero and full", 1'b0);
    run_frame(3, 11, 4'b1000, "R7 mid-frame change", 1'b1);
    run_frame(14, 6, 4'b1001, "R7 mid-frame change", 1'b1);
    for (int f = 0; f < 16; f++) run_frame(5, 13, f, "R9 sweep", 1'b0);
    run_frame(1, 1, 4'b1000, "R8 tail", 1'b0);
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(width_vld == 1'b0, "R8 strobe one cycle", int'(width_vld), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule